// File: doc/BRIEF.md
# IO Coherency Aperture Decoder

This block sits in front of the coherent path for IO masters. Each request carries an address and a flag saying whether it covers only part of a cache line. The block decides, within the same cycle, whether the request falls inside a software-programmed window of physical memory. A request inside the window is marked coherent and is routed through the snooping path. Any other request is marked non-coherent. The snoop logic that acts on the decision is not part of this block.

Software programs four settings through a simple write port:

- a window start, given as a 4 KB page number;
- a size exponent, where code N gives a window of 2^(N+2) KB;
- a flag that lets partial-line requests use the coherent path;
- a master enable.

The block also raises a configuration-error output when the settings are illegal. While that output is high, every request is non-coherent.

Top module: `ioc_aperture_decoder`

## Requirements
- R1: While reset is asserted and after reset, all four settings read as 0 with the enable off, so `coherent` and `cfg_err` are both 0.
- R2: A write with `cfg_we`=1 selects its setting by `cfg_sel`. The encodings are: 0 is the start page, from `cfg_wdata[19:0]`; 1 is the size code, from `cfg_wdata[4:0]`; 2 is the partial-line allow flag, from `cfg_wdata[0]`; 3 is the enable, from `cfg_wdata[0]`. The written value governs decisions from the cycle after the write edge. A decision made in the same cycle as a write uses the old settings.
- R3: With size code N from 0 to 20, the window covers 2^(N+12) bytes. An address hits when its bits [31:N+12] equal the same bits of the window start.
- R4: The window start is the programmed page number shifted left by 12. Code 0x11 with page 0x20000 covers 0x20000000 up to and including 0x3FFFFFFF.
- R5: When the enable is 0, every request is non-coherent.
- R6: If any of the low N bits of the start page are nonzero (the start is not aligned to the window size), `cfg_err` is 1 and no request is coherent.
- R7: A size code above 20 is illegal. It sets `cfg_err` to 1 and no request is coherent.
- R8: A request with `req_partial`=1 is non-coherent while the allow flag is 0, even if its address hits. When the allow flag is 1, such a request is coherent whenever its address hits.
- R9: `coherent` and `cfg_err` are combinational from the request and the current settings. There is no cycle of latency.
- R10: Size code 20 with start page 0 covers the whole 32-bit address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting selector (0 start page, 1 size code, 2 partial allow, 3 enable) |
| cfg_wdata | input | 32 | Write data |
| req_addr | input | 32 | Request address |
| req_partial | input | 1 | Request covers part of a cache line |
| coherent | output | 1 | Request goes through the coherent path |
| cfg_err | output | 1 | Settings are illegal (misaligned start or size code out of range) |

## Verification
Two functions can fall in the same cycle: a setting write and the combinational decision on a request. The bench provokes this on purpose, for example by enabling the window, moving it or breaking its alignment while a request is presented. It then requires that the decision in that cycle follows the old settings and that the decision in the next cycle follows the new ones. A behavioural model updates its settings only after the clock edge and compares both outputs on every cycle. This covers directed window edges and a long random mix of writes and addresses.

// File: rtl/ioc_aperture_pkg.sv
package ioc_aperture_pkg;

   // Selector values for the setting write port
   typedef enum logic [1:0] {
      SEL_PAGE  = 2'd0,
      SEL_SIZE  = 2'd1,
      SEL_PART  = 2'd2,
      SEL_EN    = 2'd3
   } cfg_sel_e;

   // The window granule is one 4 KB page
   localparam int unsigned PAGE_SHIFT = 12;

endpackage

// File: rtl/ioc_aperture_regs.sv
module ioc_aperture_regs
   import ioc_aperture_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PAGE_W = ADDR_W - PAGE_SHIFT,
   parameter int unsigned CODE_W = $clog2(PAGE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        sel,
   input  logic [ADDR_W-1:0] wdata,
   output logic [PAGE_W-1:0] page_q,
   output logic [CODE_W-1:0] code_q,
   output logic              part_q,
   output logic              en_q
);

   cfg_sel_e sel_e;
   assign sel_e = cfg_sel_e'(sel);

   // Data bits above the widest setting are never stored
   logic unused_wdata_hi;
   assign unused_wdata_hi = ^wdata[ADDR_W-1:PAGE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
         code_q <= '0;
         part_q <= 1'b0;
         en_q   <= 1'b0;
      end else if (we) begin
         unique case (sel_e)
            SEL_PAGE: page_q <= wdata[PAGE_W-1:0];
            SEL_SIZE: code_q <= wdata[CODE_W-1:0];
            SEL_PART: part_q <= wdata[0];
            SEL_EN:   en_q   <= wdata[0];
            default:  ;
         endcase
      end
   end

   AST_PAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel_e == SEL_PAGE) |=> (page_q == $past(wdata[PAGE_W-1:0]))); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && $past(rst_n)) |=> ($stable(page_q) && $stable(code_q) && $stable(part_q) && $stable(en_q))); // R2

endmodule

// File: rtl/ioc_aperture_mask.sv
module ioc_aperture_mask #(
   parameter int unsigned PAGE_W = 20,
   parameter int unsigned CODE_W = $clog2(PAGE_W + 1)
) (
   input  logic [CODE_W-1:0] code,
   output logic [PAGE_W-1:0] keep
);

   // Page bit i takes part in the compare when it lies at or above the
   // window exponent, that is when i >= code.
   for (genvar gi = 0; gi < PAGE_W; gi++) begin : g_keep
      assign keep[gi] = (code <= CODE_W'(gi));
   end

endmodule

// File: rtl/ioc_aperture_match.sv
module ioc_aperture_match
   import ioc_aperture_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PAGE_W = ADDR_W - PAGE_SHIFT,
   parameter int unsigned CODE_W = $clog2(PAGE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              partial,
   input  logic [PAGE_W-1:0] page,
   input  logic [CODE_W-1:0] code,
   input  logic              allow_part,
   input  logic              en,
   output logic              coherent,
   output logic              bad_cfg
);

   localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(PAGE_W);

   logic [PAGE_W-1:0] keep;
   logic [PAGE_W-1:0] addr_page;
   logic              code_range_bad;
   logic              misaligned;
   logic              in_window;

   ioc_aperture_mask #(
      .PAGE_W (PAGE_W),
      .CODE_W (CODE_W)
   ) u_mask (
      .code (code),
      .keep (keep)
   );

   assign addr_page = addr[ADDR_W-1:PAGE_SHIFT];

   // The byte offset inside a page never affects the decision
   logic unused_page_offset;
   assign unused_page_offset = ^addr[PAGE_SHIFT-1:0];

   assign code_range_bad = (code > MAX_CODE);
   assign misaligned     = |(page & ~keep);
   assign bad_cfg        = code_range_bad | misaligned;

   assign in_window = ((addr_page & keep) == (page & keep));

   assign coherent = en & ~bad_cfg & in_window & (~partial | allow_part);

   AST_OFF_NONCOH: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !coherent); // R5
   AST_ERR_NONCOH: assert property (@(posedge clk) disable iff (!rst_n)
      bad_cfg |-> !coherent); // R6
   AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (code > MAX_CODE) |-> bad_cfg); // R7
   AST_PART_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (partial && !allow_part) |-> !coherent); // R8

endmodule

// File: rtl/ioc_aperture_decoder.sv
module ioc_aperture_decoder
   import ioc_aperture_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT,
   localparam int unsigned CODE_W = $clog2(PAGE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_partial,
   output logic              coherent,
   output logic              cfg_err
);

   if (ADDR_W <= PAGE_SHIFT) begin : g_bad_width
      $error("ioc_aperture_decoder: ADDR_W must exceed the page shift");
   end
   if (ADDR_W > 64) begin : g_bad_wide
      $error("ioc_aperture_decoder: ADDR_W above 64 is not supported");
   end

   logic [PAGE_W-1:0] page_q;
   logic [CODE_W-1:0] code_q;
   logic              part_q;
   logic              en_q;

   ioc_aperture_regs #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W),
      .CODE_W (CODE_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .page_q (page_q),
      .code_q (code_q),
      .part_q (part_q),
      .en_q   (en_q)
   );

   ioc_aperture_match #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W),
      .CODE_W (CODE_W)
   ) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (req_addr),
      .partial    (req_partial),
      .page       (page_q),
      .code       (code_q),
      .allow_part (part_q),
      .en         (en_q),
      .coherent   (coherent),
      .bad_cfg    (cfg_err)
   );

   AST_DISABLE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'd3 && !cfg_wdata[0]) |=> !coherent); // R5
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!coherent && !cfg_err)); // R1

endmodule

// File: tb/ioc_aperture_decoder_tb.sv
module ioc_aperture_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] req_addr = '0;
   logic        req_partial = 1'b0;
   logic        coherent;
   logic        cfg_err;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // Behavioural model of the settings
   longint unsigned m_page = 0;
   int unsigned     m_code = 0;
   bit              m_part = 0;
   bit              m_en = 0;

   always #2 clk = ~clk;

   ioc_aperture_decoder u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_sel     (cfg_sel),
      .cfg_wdata   (cfg_wdata),
      .req_addr    (req_addr),
      .req_partial (req_partial),
      .coherent    (coherent),
      .cfg_err     (cfg_err)
   );

   task automatic check(input bit act, input bit exp, input string tag, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d addr=%h", tag, what, act, exp, req_addr);
      end
   endtask

   function automatic bit model_err();
      longint unsigned sz;
      if (m_code > 20) return 1;
      sz = 64'd1 << m_code;
      return (m_page % sz) != 0;
   endfunction

   function automatic bit model_coh(input logic [31:0] a, input bit p);
      longint unsigned start;
      longint unsigned sz;
      if (!m_en || model_err()) return 0;
      start = m_page << 12;
      sz = 64'd1 << (m_code + 12);
      if (!(longint'(a) >= start && longint'(a) < start + sz)) return 0;
      if (p && !m_part) return 0;
      return 1;
   endfunction

   task automatic step(input bit we, input logic [1:0] sel, input logic [31:0] wd,
                       input logic [31:0] a, input bit p, input string tag);
      @(negedge clk);
      cfg_we = we; cfg_sel = sel; cfg_wdata = wd; req_addr = a; req_partial = p;
      #1;
      check(coherent, model_coh(a, p), tag, "coherent");
      check(cfg_err, model_err(), tag, "cfg_err");
      @(posedge clk);
      if (we) begin
         case (sel)
            2'd0: m_page = longint'(wd & 32'h000F_FFFF);
            2'd1: m_code = wd & 32'h1F;
            2'd2: m_part = wd[0];
            default: m_en = wd[0];
         endcase
      end
   endtask

   task automatic look(input logic [31:0] a, input bit p, input string tag);
      step(0, 2'd0, 32'h0, a, p, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL R9 watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: outputs quiet during reset
      repeat (3) @(negedge clk);
      #1;
      check(coherent, 0, "R1", "coherent in reset");
      check(cfg_err, 0, "R1", "cfg_err in reset");
      @(negedge clk);
      rst_n = 1'b1;
      look(32'h0000_0000, 0, "R1");
      look(32'h0000_0FFF, 1, "R1");

      // R5: whole-space window but disabled
      step(1, 2'd1, 32'd20, 32'h1234_5678, 0, "R5");
      look(32'h8000_0000, 0, "R5");
      // R2: enable write and request in the same cycle use old enable
      step(1, 2'd3, 32'd1, 32'h8000_0000, 0, "R2");
      look(32'h8000_0000, 0, "R10");
      look(32'hFFFF_FFFF, 0, "R10");
      look(32'h0000_0000, 0, "R10");

      // R3 R4: 512 MB window at 0x20000000
      step(1, 2'd1, 32'h11, 32'h0, 0, "R3");
      step(1, 2'd0, 32'h0002_0000, 32'h2000_0000, 0, "R2");
      look(32'h2000_0000, 0, "R4");
      look(32'h3FFF_FFFF, 0, "R4");
      look(32'h4000_0000, 0, "R4");
      look(32'h1FFF_FFFF, 0, "R4");

      // R6: misaligned start, then write back in the same cycle as a request
      step(1, 2'd0, 32'h0003_0000, 32'h3000_0000, 0, "R2");
      look(32'h3000_0000, 0, "R6");
      look(32'h2000_0000, 0, "R6");
      step(1, 2'd0, 32'h0002_0000, 32'h2000_0000, 0, "R2");
      look(32'h2000_0000, 0, "R6");

      // R7: size code out of range
      step(1, 2'd1, 32'd21, 32'h2000_0000, 0, "R7");
      look(32'h2000_0000, 0, "R7");
      step(1, 2'd1, 32'd31, 32'h2000_0000, 0, "R7");
      look(32'h2000_0000, 0, "R7");

      // R8: partial-line requests
      step(1, 2'd1, 32'h12, 32'h0, 0, "R8");
      step(1, 2'd0, 32'h0004_0000, 32'h4000_0000, 1, "R8");
      look(32'h4000_0040, 1, "R8");
      look(32'h4000_0040, 0, "R8");
      step(1, 2'd2, 32'd1, 32'h7FFF_FFF0, 1, "R8");
      look(32'h7FFF_FFF0, 1, "R8");
      look(32'h8000_0000, 1, "R8");

      // R3: smallest window, 4 KB at page 0x12345
      step(1, 2'd1, 32'd0, 32'h0, 0, "R3");
      step(1, 2'd0, 32'hFFF1_2345, 32'h0, 0, "R3");
      look(32'h1234_5000, 0, "R3");
      look(32'h1234_5FFF, 1, "R3");
      look(32'h1234_6000, 0, "R3");
      look(32'h1234_4FFF, 0, "R3");

      // R9 R3: random mix, every cycle compared against the model
      for (int i = 0; i < 2000; i++) begin
         bit w;
         logic [1:0] s;
         logic [31:0] d;
         logic [31:0] a;
         w = ($urandom_range(0, 3) == 0);
         s = 2'($urandom_range(0, 3));
         d = $urandom;
         if (s == 2'd1) d = 32'($urandom_range(0, 22));
         if (s == 2'd0 && $urandom_range(0, 1) == 1) d = d & 32'hFFFF_0000;
         if (s >= 2'd2 && $urandom_range(0, 3) != 0) d = 32'd1;
         a = $urandom;
         if ($urandom_range(0, 1) == 1) a = 32'(m_page << 12) ^ (32'($urandom) >> (20 - (m_code % 21)));
         step(w, s, d, a, bit'($urandom_range(0, 1)), "R9");
      end

      // R10: whole space again
      step(1, 2'd0, 32'h0, 32'h0, 0, "R10");
      step(1, 2'd1, 32'd20, 32'h0, 0, "R10");
      step(1, 2'd3, 32'd1, 32'h0, 0, "R10");
      look(32'hFFFF_FFFF, 0, "R10");
      look(32'h0000_0000, 0, "R10");

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule